// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a clocked host and a 32K x 8 fully static asynchronous RAM. The host hands it one word at a time: an address, a read/write flag and, for writes, a data byte. The block produces the RAM's active-low chip select, output enable and write strobe with whole-cycle timing. It owns the tri-state driver on the shared data bus, and it hands read data back with a one-cycle valid pulse.

Each minimum RAM timing is a parameter in nanoseconds, alongside the clock period. Every timing is turned into a cycle count by rounding up, with a floor of one cycle. A read keeps chip select and output enable low for the longest read timing, then samples the bus on the last edge of that window. After every read the strobes stay high for the output-release time, so the RAM's lingering output can never meet the block's own driver. A write is timed by the write strobe. Output enable stays high throughout. The data driver switches on only after the RAM's write-strobe release time, and it stays on through the rising edge of the strobe. Chip select stays low afterwards until the full write cycle time has passed.

Top module: `async_sram_ctrl`

## Requirements
- R1: Out of reset and whenever the block is idle, `ready` is 1, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are all 1, the data driver is off and `rvalid` is 0.
- R2: A read holds `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 with a stable address for exactly ceil(max(T_RC, T_AA, T_OA)/CLK_NS) cycles (20 at defaults). It samples `sram_dq` on the last edge of that window. It raises `rvalid` for exactly one cycle, with the sampled byte on `rdata`.
- R3: After a read, all three strobes stay high for ceil(T_OFF/CLK_NS) cycles (6 at defaults) before `ready` returns. A read therefore keeps the block busy for 26 cycles at defaults, and no write strobe falls sooner than T_OFF after output enable rises.
- R4: A write keeps `sram_oe_n`=1 and `sram_ce_n`=0 and holds `sram_we_n`=0 for W = max(ceil(T_WP), ceil(T_ADDR_END), ceil(T_CE_END), ceil(T_WOFF)+ceil(T_DS)) cycles, each in units of CLK_NS (16 at defaults).
- R5: The data driver is on only while chip select is low and output enable is high. It turns on ceil(T_WOFF/CLK_NS) cycles after the write strobe falls and is still on when the strobe rises, so the data setup time is at least ceil(T_DS/CLK_NS) cycles.
- R6: After the write strobe rises, chip select stays low for max(1, ceil(T_WC/CLK_NS) - W) cycles (4 at defaults). Chip select is therefore low for 20 cycles per write at defaults.
- R7: A request is taken only on a cycle where `req` and `ready` are both 1. `ready` drops on the next cycle and stays 0 until the operation and its turnaround end. A request raised while `ready` is 0 has no effect on the RAM.
- R8: A byte written to any address, including 0x0000 and 0x7FFF, reads back unchanged. A later write to the same address replaces it.
- R9: `rvalid` never pulses for a write.
- R10: Every timing parameter becomes cycles by ceiling division with a floor of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Block idle, request may be taken |
| rvalid | output | 1 | One-cycle pulse with read data |
| rdata | output | 8 | Captured read byte |
| sram_addr | output | 15 | RAM address |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_dq | inout | 8 | Shared RAM data bus |

## Verification
The bench's RAM model returns the complement of the stored byte until the address has been applied for one nanosecond short of T_AA. A read window one cycle too short therefore returns inverted data. The bench measures at nanosecond resolution the gap between output enable rising and the next write strobe falling. A missing read-to-write turnaround would show a write strobe within T_OFF of the read. The bench also measures the strobe width: a pulse cut below T_WP, or a driver released before the strobe rises, would fail the width check or store the wrong byte. Requests held high during a busy write check that the block ignores requests while busy: a block that took one would issue a second strobe and overwrite the stored byte.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_RTURN = 3'd2,
    ST_WR    = 3'd3,
    ST_WHOLD = 3'd4
  } ctl_st_e;

  // R10: nanoseconds to whole cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                            input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int unsigned TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic [TW-1:0] cnt,
  output logic          done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int unsigned TW   = 5,
  parameter int unsigned C_RD = 20,
  parameter int unsigned C_OD = 6,
  parameter int unsigned C_W  = 16,
  parameter int unsigned C_H  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic          tmr_done,
  output ctl_st_e       st,
  output logic          accept,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val
);
  localparam logic [TW-1:0] LD_RD = TW'(C_RD - 1);
  localparam logic [TW-1:0] LD_OD = TW'(C_OD - 1);
  localparam logic [TW-1:0] LD_W  = TW'(C_W - 1);
  localparam logic [TW-1:0] LD_H  = TW'(C_H - 1);

  ctl_st_e st_nx;

  assign accept = req && (st == ST_IDLE);

  always_comb begin
    st_nx    = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        st_nx    = req_wr ? ST_WR : ST_RD;
        tmr_val  = req_wr ? LD_W : LD_RD;
      end
      ST_RD: if (tmr_done) begin
        st_nx = ST_RTURN; tmr_load = 1'b1; tmr_val = LD_OD;
      end
      ST_RTURN: if (tmr_done) st_nx = ST_IDLE;
      ST_WR: if (tmr_done) begin
        st_nx = ST_WHOLD; tmr_load = 1'b1; tmr_val = LD_H;
      end
      ST_WHOLD: if (tmr_done) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end
endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          rd_cap,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  // address and write byte held from acceptance to the next acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr <= '0;
      wdata_q   <= '0;
    end else if (accept) begin
      sram_addr <= req_addr;
      wdata_q   <= req_wdata;
    end
  end

  // read byte taken on the last edge of the access window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_cap;
      if (rd_cap) rdata <= dq_in;
    end
  end
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned CLK_NS     = 5,
  parameter int unsigned AW         = 15,
  parameter int unsigned DW         = 8,
  parameter int unsigned T_RC       = 100,
  parameter int unsigned T_AA       = 100,
  parameter int unsigned T_OA       = 50,
  parameter int unsigned T_OFF      = 30,
  parameter int unsigned T_WC       = 100,
  parameter int unsigned T_ADDR_END = 80,
  parameter int unsigned T_CE_END   = 80,
  parameter int unsigned T_WP       = 60,
  parameter int unsigned T_DS       = 35,
  parameter int unsigned T_WOFF     = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          rvalid,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  inout  wire  [DW-1:0] sram_dq
);
  localparam int unsigned C_RD  = ns_to_cyc(umax(umax(T_RC, T_AA), T_OA), CLK_NS);
  localparam int unsigned C_OD  = ns_to_cyc(T_OFF, CLK_NS);
  localparam int unsigned C_WOD = ns_to_cyc(T_WOFF, CLK_NS);
  localparam int unsigned C_DS  = ns_to_cyc(T_DS, CLK_NS);
  localparam int unsigned C_W   = umax(umax(ns_to_cyc(T_WP, CLK_NS),
                                            ns_to_cyc(T_ADDR_END, CLK_NS)),
                                       umax(ns_to_cyc(T_CE_END, CLK_NS),
                                            C_WOD + C_DS));
  localparam int unsigned C_WC  = ns_to_cyc(T_WC, CLK_NS);
  localparam int unsigned C_H   = (C_WC > C_W) ? (C_WC - C_W) : 1;
  localparam int unsigned C_MAX = umax(umax(C_RD, C_OD), umax(C_W, C_H));
  localparam int unsigned TW    = $clog2(C_MAX + 1);
  localparam logic [TW-1:0] DRV_AT = TW'(C_W - 1 - C_WOD);

  ctl_st_e       st;
  logic          accept, tmr_load, tmr_done;
  logic [TW-1:0] tmr_val, tmr_cnt;
  logic [DW-1:0] wdata_q;

  // named internal events, observed by the bound checker
  logic rd_cap;
  logic drv_on;

  asram_fsm #(.TW(TW), .C_RD(C_RD), .C_OD(C_OD), .C_W(C_W), .C_H(C_H)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .tmr_done(tmr_done),
    .st(st), .accept(accept), .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  asram_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .cnt(tmr_cnt), .done(tmr_done)
  );

  asram_dpath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rd_cap(rd_cap),
    .req_addr(req_addr), .req_wdata(req_wdata), .dq_in(sram_dq),
    .sram_addr(sram_addr), .wdata_q(wdata_q), .rdata(rdata), .rvalid(rvalid)
  );

  assign rd_cap = (st == ST_RD) && tmr_done;
  // driver waits out the strobe-release time, then holds through the rising strobe
  assign drv_on = (st == ST_WHOLD) || ((st == ST_WR) && (tmr_cnt <= DRV_AT));
  assign sram_dq = drv_on ? wdata_q : {DW{1'bz}};

  assign ready     = (st == ST_IDLE);
  assign sram_ce_n = !((st == ST_RD) || (st == ST_WR) || (st == ST_WHOLD));
  assign sram_oe_n = (st != ST_RD);
  assign sram_we_n = (st != ST_WR);
endmodule

// File: rtl/asram_chk.sv
module asram_chk #(
  parameter int unsigned C_OD  = 6,
  parameter int unsigned C_WMIN = 16,
  parameter int unsigned C_DS  = 7
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic drv_on,
  input logic cap,
  input logic req,
  input logic ready,
  input logic rvalid
);
  localparam int unsigned SAT = 1000;
  int unsigned oe_hi_cnt, we_lo_cnt, drv_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hi_cnt <= SAT;
      we_lo_cnt <= 0;
      drv_cnt   <= 0;
    end else begin
      oe_hi_cnt <= !oe_n ? 0 : ((oe_hi_cnt < SAT) ? oe_hi_cnt + 1 : SAT);
      we_lo_cnt <= we_n ? 0 : ((we_lo_cnt < SAT) ? we_lo_cnt + 1 : SAT);
      drv_cnt   <= !drv_on ? 0 : ((drv_cnt < SAT) ? drv_cnt + 1 : SAT);
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ce_n && oe_n && we_n && !drv_on));

  assert_cap_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> (!ce_n && !oe_n && we_n));

  assert_cap_then_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> rvalid);

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  assert_turnaround_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> (oe_hi_cnt >= C_OD));

  assert_oe_off_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (oe_n && !ce_n));

  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_lo_cnt >= C_WMIN));

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drv_on |-> (oe_n && !ce_n));

  assert_data_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (drv_on && drv_cnt >= C_DS));

  assert_busy_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready) |=> !ready);
endmodule

bind async_sram_ctrl asram_chk #(.C_OD(C_OD), .C_WMIN(C_W), .C_DS(C_DS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(sram_ce_n), .oe_n(sram_oe_n),
  .we_n(sram_we_n), .drv_on(drv_on), .cap(rd_cap), .req(req),
  .ready(ready), .rvalid(rvalid)
);

// File: tb/sim_async_sram_ctrl.sv
`timescale 1ns/100ps
module sim_async_sram_ctrl;
  localparam int CLK = 5;
  localparam int T_RC = 100, T_AA = 100, T_OA = 50, T_OFF = 30, T_WC = 100;
  localparam int T_AE = 80, T_CE = 80, T_WP = 60, T_DS = 35, T_WOFF = 25;

  // bench's own cycle arithmetic: count periods until the time is covered
  function automatic int cyc(input int ns);
    int c = 0;
    while (c * CLK < ns) c++;
    if (c < 1) c = 1;
    return c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD = cyc(mx(mx(T_RC, T_AA), T_OA));
  localparam int E_OD = cyc(T_OFF);
  localparam int E_W  = mx(mx(cyc(T_WP), cyc(T_AE)), mx(cyc(T_CE), cyc(T_WOFF) + cyc(T_DS)));
  localparam int E_H  = mx(1, cyc(T_WC) - E_W);

  logic clk = 0, rst_n = 0, req = 0, req_wr = 0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic ready, rvalid, ce_n, oe_n, we_n;
  logic [7:0] rdata;
  logic [14:0] sram_addr;
  wire  [7:0] sram_dq;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  async_sram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rvalid(rvalid), .rdata(rdata),
    .sram_addr(sram_addr), .sram_ce_n(ce_n), .sram_oe_n(oe_n),
    .sram_we_n(we_n), .sram_dq(sram_dq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---- behavioural RAM model ----
  logic [7:0] mem [int];
  logic       m_on = 0;
  logic [7:0] m_val = '0;
  logic [14:0] m_addr = '0;
  realtime    t_acc = 0, t_wf = 0, t_oe_rise = 0;
  bit         had_read = 0;
  logic [14:0] wf_addr;

  function automatic logic [7:0] peek(input logic [14:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  assign sram_dq = m_on ? m_val : 8'hzz;

  initial forever begin
    bit on;
    #0.5;
    on = !ce_n && !oe_n && we_n;
    if (on && (!m_on || sram_addr != m_addr)) begin
      t_acc  = $realtime;
      m_addr = sram_addr;
    end
    m_on = on;
    // data not settled until one ns short of the access time
    if (on) m_val = ($realtime - t_acc >= T_AA - 1) ? peek(m_addr) : ~peek(m_addr);
  end

  always @(posedge oe_n) begin t_oe_rise = $realtime; had_read = 1; end

  always @(negedge we_n) begin
    t_wf = $realtime;
    wf_addr = sram_addr;
    // R3: write strobe never falls within the output-release time of a read
    if (had_read) check($realtime - t_oe_rise >= T_OFF, "R3 turnaround ns",
                        int'($realtime - t_oe_rise), T_OFF);
  end

  always @(posedge we_n) if (!ce_n) begin
    check($realtime - t_wf >= T_WP, "R4 strobe width ns", int'($realtime - t_wf), T_WP);
    check(sram_addr == wf_addr, "R4 address stable", int'(sram_addr), int'(wf_addr));
    mem[int'(sram_addr)] = sram_dq;
  end

  // ---- one operation, measured at falling edges ----
  task automatic run_op(input bit wr, input logic [14:0] a, input logic [7:0] d,
                        input int junk, output int busy, output int n_oe,
                        output int n_we, output int n_ce, output int n_rv,
                        output logic [7:0] got);
    busy = 0; n_oe = 0; n_we = 0; n_ce = 0; n_rv = 0; got = '0;
    @(negedge clk);
    req = 1; req_wr = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (k < junk) begin
        req = 1; req_wdata = ~d;          // R7: must be ignored while busy
      end else req = 0;
      if (!oe_n) n_oe++;
      if (!we_n) n_we++;
      if (!ce_n) n_ce++;
      if (rvalid) begin n_rv++; got = rdata; end
      if (ready) break;
      busy++;
    end
    req = 0;
  endtask

  // {write, address, byte}
  localparam logic [23:0] VEC [13] = '{
    {1'b1, 15'h0000, 8'h3C}, {1'b1, 15'h7FFF, 8'hC3}, {1'b1, 15'h1234, 8'h5A},
    {1'b1, 15'h4321, 8'hA5}, {1'b0, 15'h0000, 8'h3C}, {1'b0, 15'h7FFF, 8'hC3},
    {1'b1, 15'h1234, 8'hFF}, {1'b0, 15'h1234, 8'hFF}, {1'b0, 15'h4321, 8'hA5},
    {1'b1, 15'h00FF, 8'h00}, {1'b0, 15'h00FF, 8'h00}, {1'b1, 15'h2AAA, 8'h55},
    {1'b0, 15'h2AAA, 8'h55}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog expired actual=busy expected=idle");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int busy, n_oe, n_we, n_ce, n_rv;
    logic [7:0] got;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(ready && ce_n && oe_n && we_n && !rvalid, "R1 reset idle",
          {ready, ce_n, oe_n, we_n, rvalid}, 5'b11110);

    for (int i = 0; i < 13; i++) begin
      bit wr = VEC[i][23];
      logic [14:0] a = VEC[i][22:8];
      logic [7:0] d = VEC[i][7:0];
      run_op(wr, a, d, 0, busy, n_oe, n_we, n_ce, n_rv, got);
      if (wr) begin
        check(n_we == E_W, "R4 strobe cycles", n_we, E_W);
        check(n_oe == 0, "R4 output enable off", n_oe, 0);
        check(n_ce == E_W + E_H, "R6 select cycles", n_ce, E_W + E_H);
        check(n_rv == 0, "R9 no valid on write", n_rv, 0);
        check(busy == E_W + E_H, "R7 write busy", busy, E_W + E_H);
      end else begin
        check(got == d, "R8 read-back", got, d);
        check(n_rv == 1, "R2 one valid pulse", n_rv, 1);
        check(n_oe == E_RD, "R2 read window R10", n_oe, E_RD);
        check(busy == E_RD + E_OD, "R3 read busy", busy, E_RD + E_OD);
      end
    end

    // R7: requests held during a busy write change nothing
    run_op(1'b1, 15'h0100, 8'h11, 5, busy, n_oe, n_we, n_ce, n_rv, got);
    check(n_we == E_W, "R7 single strobe", n_we, E_W);
    run_op(1'b0, 15'h0100, 8'h11, 0, busy, n_oe, n_we, n_ce, n_rv, got);
    check(got == 8'h11, "R7 busy request ignored", got, 8'h11);

    // R8: overwrite of the top address
    run_op(1'b1, 15'h7FFF, 8'h96, 0, busy, n_oe, n_we, n_ce, n_rv, got);
    run_op(1'b0, 15'h7FFF, 8'h00, 0, busy, n_oe, n_we, n_ce, n_rv, got);
    check(got == 8'h96, "R8 overwrite top address", got, 8'h96);

    // R1: quiet while idle
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(ready && ce_n && oe_n && we_n && !rvalid, "R1 idle strobes",
            {ready, ce_n, oe_n, we_n, rvalid}, 5'b11110);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule